// File: doc/BRIEF.md
# I2C Slave Address Matcher and Clock-Stretch Controller

This block handles the address phase of an I2C slave and decides when the slave holds SCL low. It does not shift bits or store data. The bit-level shifter tells it about START and STOP conditions and hands it each completed byte. The block compares the first byte after START with a programmed address, in 7-bit or 10-bit form, and can also accept the general-call address. It then tracks whether the transfer is a master write or a master read, and it requests an ACK for every byte the slave has to acknowledge.

When stretching is enabled, the block asks for SCL to be held low at defined points. These points are an address match, a read byte that finishes with nothing left to send, a write byte that arrives while the receive storage is full, and optionally every write byte so that the host can decide on the ACK. A two-bit code reports why the line is held. The host releases the line with a clear strobe. The release only takes effect once the condition behind the stretch has also gone away.

Top module: `i2c_slv_addr_stretch`

## Requirements
- R1: After reset, match_o, ack_o and scl_hold_o are low and cause_o is 0.
- R2: 7-bit mode. The first byte after START matches when byte[7:1] equals addr_cfg_i[6:0], and bit 0 of that byte is R/W (1 = read). Bits [14:7] of addr_cfg_i are ignored. ack_o pulses the cycle after the byte. match_o stays high until the next START or STOP.
- R3: An address byte that does not match gives no ACK, so SDA stays released. Every later byte is ignored, with no ACK and no match, until the next START.
- R4: The byte 0x00 after START matches as a write only when bcast_en_i is high.
- R5: 10-bit mode. addr_cfg_i[6:0] holds 7'b11110 followed by address bits [9:8], and addr_cfg_i[14:7] holds address bits [7:0]. A first byte whose [7:1] equals addr_cfg_i[6:0] and whose R/W bit is 0 is ACKed without a match. A second byte equal to addr_cfg_i[14:7] then completes a write match.
- R6: 10-bit mode. After a complete 10-bit write match, a repeated START followed by the header byte with R/W = 1 gives a read match. The same header with R/W = 1 and no earlier selection since the last STOP is not ACKed.
- R7: While matched for a write, every data byte is ACKed. While matched for a read, no ACK is driven.
- R8: scl_hold_o never rises while stretch_en_i is low. With stretching enabled, an address match holds SCL with cause 0.
- R9: In a read, a byte that completes while tx_empty_i is high holds SCL with cause 1.
- R10: In a write, a byte that arrives while rx_full_i is high holds SCL with cause 2. This takes precedence over cause 3.
- R11: In a write with ack_hold_en_i high and rx_full_i low, each data byte holds SCL with cause 3.
- R12: The hold drops the cycle after both conditions are true: a clr_i strobe has been seen, and the cause is resolved (cause 1 needs tx_empty_i low, cause 2 needs rx_full_i low). A clear given early is remembered. cause_o reads 0 while no hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START detected (one-cycle pulse) |
| stop_i | input | 1 | STOP detected (one-cycle pulse) |
| byte_valid_i | input | 1 | A byte has completed on the bus (one-cycle pulse) |
| byte_i | input | 8 | Completed byte; for address bytes bit 0 is R/W |
| addr_cfg_i | input | 15 | Packed compare value for the slave address |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| bcast_en_i | input | 1 | Accept the general-call address |
| stretch_en_i | input | 1 | Allow clock stretching |
| ack_hold_en_i | input | 1 | Stretch before each write-data ACK |
| tx_empty_i | input | 1 | Transmit storage is empty |
| rx_full_i | input | 1 | Receive storage is full |
| clr_i | input | 1 | Host stretch-release strobe |
| match_o | output | 1 | Slave is addressed |
| ack_o | output | 1 | Pulse: drive ACK for the byte just completed |
| scl_hold_o | output | 1 | Hold SCL low |
| cause_o | output | 2 | Stretch reason: 0 address, 1 TX empty, 2 RX full, 3 ACK decision |

## Verification
The address matcher is driven with several kinds of address byte, each aimed at one way the compare could go wrong:
- The correct 7-bit address with either R/W value.
- A value that differs only in bit 0 of the address.
- A correct address with junk in the unused upper configuration bits, which shows whether only the low seven bits are compared.
- A general-call byte with the broadcast enable on and off.

The 10-bit cases cover several sequences:
- A full write sequence.
- A correct header followed by a wrong low byte.
- A read header after a repeated START.
- A read header sent with no earlier selection, which separates a proper R/W check from a plain compare of the header.

The stretch cases send FIFO status changes before and after the clear strobe. These runs show whether release depends on the strobe alone or on the strobe together with the underlying condition. Cases where rx_full_i and ack_hold_en_i are both active check the priority between the two cause codes.

// File: rtl/i2c_slv_addr_stretch.sv
module i2c_slv_addr_stretch #(
  parameter int ADDR_CFG_W = 15,
  parameter int BYTE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  byte_valid_i,
  input  logic [BYTE_W-1:0]     byte_i,
  input  logic [ADDR_CFG_W-1:0] addr_cfg_i,
  input  logic                  ten_bit_i,
  input  logic                  bcast_en_i,
  input  logic                  stretch_en_i,
  input  logic                  ack_hold_en_i,
  input  logic                  tx_empty_i,
  input  logic                  rx_full_i,
  input  logic                  clr_i,
  output logic                  match_o,
  output logic                  ack_o,
  output logic                  scl_hold_o,
  output logic [1:0]            cause_o
);

  localparam int HDR_W = BYTE_W - 1;
  localparam logic [1:0] C_ADDR = 2'd0;
  localparam logic [1:0] C_TXE  = 2'd1;
  localparam logic [1:0] C_RXF  = 2'd2;
  localparam logic [1:0] C_ACK  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR2, S_WR, S_RD} st_t;

  st_t        st_q, st_n;
  logic       match_q, match_n;
  logic       ack_q, ack_n;
  logic       sel10_q, sel10_n;
  logic       hold_q, clr_seen_q;
  logic [1:0] cause_q;
  logic       addr_ev, wr_ev, rd_ev;

  wire hdr_hit = byte_i[BYTE_W-1:1] == addr_cfg_i[HDR_W-1:0];
  wire lo_hit  = byte_i == addr_cfg_i[HDR_W +: BYTE_W];
  wire gc_hit  = bcast_en_i && (byte_i == '0);
  wire rw_bit  = byte_i[0];

  always_comb begin
    st_n    = st_q;
    match_n = match_q;
    sel10_n = sel10_q;
    ack_n   = 1'b0;
    addr_ev = 1'b0;
    wr_ev   = 1'b0;
    rd_ev   = 1'b0;
    if (stop_i) begin
      st_n    = S_IDLE;
      match_n = 1'b0;
      sel10_n = 1'b0;
    end else if (start_i) begin
      st_n    = S_ADDR;
      match_n = 1'b0;
    end else if (byte_valid_i) begin
      unique case (st_q)
        S_ADDR: begin
          if (gc_hit) begin
            st_n = S_WR; match_n = 1'b1; ack_n = 1'b1; addr_ev = 1'b1;
          end else if (!ten_bit_i) begin
            if (hdr_hit) begin
              st_n = rw_bit ? S_RD : S_WR;
              match_n = 1'b1; ack_n = 1'b1; addr_ev = 1'b1;
            end else begin
              st_n = S_IDLE;
            end
          end else if (hdr_hit && !rw_bit) begin
            st_n = S_ADDR2; ack_n = 1'b1; sel10_n = 1'b0;
          end else if (hdr_hit && rw_bit && sel10_q) begin
            st_n = S_RD; match_n = 1'b1; ack_n = 1'b1; addr_ev = 1'b1;
          end else begin
            st_n = S_IDLE; sel10_n = 1'b0;
          end
        end
        S_ADDR2: begin
          if (lo_hit) begin
            st_n = S_WR; match_n = 1'b1; ack_n = 1'b1; addr_ev = 1'b1;
            sel10_n = 1'b1;
          end else begin
            st_n = S_IDLE;
          end
        end
        S_WR: begin
          ack_n = 1'b1; wr_ev = 1'b1;
        end
        S_RD: rd_ev = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      match_q <= 1'b0;
      ack_q   <= 1'b0;
      sel10_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      match_q <= match_n;
      ack_q   <= ack_n;
      sel10_q <= sel10_n;
    end
  end

  logic       ev_any;
  logic [1:0] ev_cause;
  always_comb begin
    ev_any   = 1'b1;
    ev_cause = C_ADDR;
    if (addr_ev)                      ev_cause = C_ADDR;
    else if (rd_ev && tx_empty_i)     ev_cause = C_TXE;
    else if (wr_ev && rx_full_i)      ev_cause = C_RXF;
    else if (wr_ev && ack_hold_en_i)  ev_cause = C_ACK;
    else                              ev_any   = 1'b0;
  end

  logic resolved;
  always_comb begin
    unique case (cause_q)
      C_TXE:   resolved = !tx_empty_i;
      C_RXF:   resolved = !rx_full_i;
      default: resolved = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      clr_seen_q <= 1'b0;
      cause_q    <= C_ADDR;
    end else if (hold_q) begin
      if ((clr_i || clr_seen_q) && resolved) begin
        hold_q     <= 1'b0;
        clr_seen_q <= 1'b0;
      end else if (clr_i) begin
        clr_seen_q <= 1'b1;
      end
    end else if (stretch_en_i && ev_any) begin
      hold_q     <= 1'b1;
      cause_q    <= ev_cause;
      clr_seen_q <= 1'b0;
    end
  end

  assign match_o    = match_q;
  assign ack_o      = ack_q;
  assign scl_hold_o = hold_q;
  assign cause_o    = hold_q ? cause_q : C_ADDR;

  assert_hold_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_o) |-> $past(stretch_en_i));

  assert_release_after_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_hold_o) |-> $past(clr_i || clr_seen_q));

  assert_rxfull_keeps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold_o && cause_o == C_RXF && rx_full_i) |=> scl_hold_o);

  assert_txempty_keeps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold_o && cause_o == C_TXE && tx_empty_i) |=> scl_hold_o);

  assert_stop_drops_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || start_i) |=> !match_o);

  assert_idle_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && byte_valid_i && !start_i && !stop_i) |=> (!ack_o && !match_o));

  assert_read_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD && byte_valid_i && !start_i && !stop_i) |=> !ack_o);

endmodule

// File: tb/i2c_slv_addr_stretch_tb.sv
module i2c_slv_addr_stretch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, byte_valid_i = 0, clr_i = 0;
  logic [7:0] byte_i = '0;
  logic [14:0] addr_cfg_i = 15'h0042;
  logic ten_bit_i = 0, bcast_en_i = 0, stretch_en_i = 0, ack_hold_en_i = 0;
  logic tx_empty_i = 0, rx_full_i = 0;
  logic match_o, ack_o, scl_hold_o;
  logic [1:0] cause_o;

  int checks = 0, errors = 0;
  logic [4:0] expq[$];
  string reqq[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_slv_addr_stretch u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .addr_cfg_i(addr_cfg_i),
    .ten_bit_i(ten_bit_i), .bcast_en_i(bcast_en_i), .stretch_en_i(stretch_en_i),
    .ack_hold_en_i(ack_hold_en_i), .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i),
    .clr_i(clr_i), .match_o(match_o), .ack_o(ack_o), .scl_hold_o(scl_hold_o),
    .cause_o(cause_o)
  );

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [4:0] e, a;
      string r;
      e = expq.pop_front();
      r = reqq.pop_front();
      a = {match_o, ack_o, scl_hold_o, cause_o};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: got match/ack/hold/cause=%b expected %b", r, a, e);
      end
    end
  end

  task automatic cyc(input logic st, input logic sp, input logic bv,
                     input logic [7:0] b, input logic cl,
                     input logic m, input logic a, input logic h,
                     input logic [1:0] c, input string r);
    @(negedge clk);
    start_i = st; stop_i = sp; byte_valid_i = bv; byte_i = b; clr_i = cl;
    @(posedge clk);
    #1;
    expq.push_back({m, a, h, c});
    reqq.push_back(r);
    start_i = 0; stop_i = 0; byte_valid_i = 0; clr_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0,0,0,8'h00,0, 0,0,0,0, "R1 reset");
    // 7-bit write match and data ACK
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R2 start");
    cyc(0,0,1,8'h84,0, 1,1,0,0, "R2 7-bit match");
    cyc(0,0,1,8'h5A,0, 1,1,0,0, "R7 write data ack");
    cyc(0,0,0,8'h00,0, 1,0,0,0, "R2 match held");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R2 stop clears");
    // upper config bits ignored
    addr_cfg_i = 15'h7F42;
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R2 start");
    cyc(0,0,1,8'h84,0, 1,1,0,0, "R2 upper bits ignored");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R2 stop");
    addr_cfg_i = 15'h0042;
    // mismatch
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R3 start");
    cyc(0,0,1,8'h86,0, 0,0,0,0, "R3 mismatch nack");
    cyc(0,0,1,8'h84,0, 0,0,0,0, "R3 ignored until start");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R3 stop");
    // broadcast
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R4 start");
    cyc(0,0,1,8'h00,0, 0,0,0,0, "R4 general call disabled");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R4 stop");
    bcast_en_i = 1;
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R4 start");
    cyc(0,0,1,8'h00,0, 1,1,0,0, "R4 general call enabled");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R4 stop");
    bcast_en_i = 0;
    // stretching on write
    stretch_en_i = 1; ack_hold_en_i = 1; rx_full_i = 1;
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R8 start");
    cyc(0,0,1,8'h84,0, 1,1,1,0, "R8 address stretch");
    cyc(0,0,0,8'h00,0, 1,0,1,0, "R12 hold waits clear");
    cyc(0,0,0,8'h00,1, 1,0,0,0, "R12 clear releases");
    cyc(0,0,1,8'h11,0, 1,1,1,2, "R10 rx full over ack hold");
    cyc(0,0,0,8'h00,1, 1,0,1,2, "R12 clear while full");
    rx_full_i = 0;
    cyc(0,0,0,8'h00,0, 1,0,0,0, "R12 release after resolve");
    cyc(0,0,1,8'h22,0, 1,1,1,3, "R11 ack hold");
    cyc(0,0,0,8'h00,1, 1,0,0,0, "R12 ack hold released");
    ack_hold_en_i = 0;
    cyc(0,0,1,8'h33,0, 1,1,0,0, "R7 no stretch without cause");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R2 stop");
    // stretching on read
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R9 start");
    cyc(0,0,1,8'h85,0, 1,1,1,0, "R8 read address stretch");
    cyc(0,0,0,8'h00,1, 1,0,0,0, "R12 release");
    tx_empty_i = 1;
    cyc(0,0,1,8'hAA,0, 1,0,1,1, "R9 tx empty stretch");
    cyc(0,0,0,8'h00,1, 1,0,1,1, "R12 clear while empty");
    tx_empty_i = 0;
    cyc(0,0,0,8'h00,0, 1,0,0,0, "R12 release after refill");
    cyc(0,0,1,8'hBB,0, 1,0,0,0, "R7 read byte no ack");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R2 stop");
    // stretching disabled
    stretch_en_i = 0; rx_full_i = 1;
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R8 start");
    cyc(0,0,1,8'h84,0, 1,1,0,0, "R8 no hold when disabled");
    cyc(0,0,1,8'h44,0, 1,1,0,0, "R8 rx full no hold");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R8 stop");
    rx_full_i = 0;
    // 10-bit address 0x2A5
    ten_bit_i = 1; addr_cfg_i = 15'h52FA;
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R5 start");
    cyc(0,0,1,8'hF4,0, 0,1,0,0, "R5 header ack");
    cyc(0,0,1,8'hA5,0, 1,1,0,0, "R5 low byte match");
    cyc(0,0,1,8'h01,0, 1,1,0,0, "R7 10-bit write data");
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R6 repeated start");
    cyc(0,0,1,8'hF5,0, 1,1,0,0, "R6 10-bit read match");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R6 stop");
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R6 start");
    cyc(0,0,1,8'hF5,0, 0,0,0,0, "R6 read header unselected");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R6 stop");
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R5 start");
    cyc(0,0,1,8'hF4,0, 0,1,0,0, "R5 header ack");
    cyc(0,0,1,8'hA4,0, 0,0,0,0, "R5 wrong low byte");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R5 stop");
    cyc(1,0,0,8'h00,0, 0,0,0,0, "R5 start");
    cyc(0,0,1,8'h84,0, 0,0,0,0, "R5 7-bit form rejected");
    cyc(0,1,0,8'h00,0, 0,0,0,0, "R5 stop");
    @(negedge clk);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule